// File: doc/BRIEF.md
# Redundant Interlock Voter

This block decides whether a protected discharge loop may stay closed. It receives three independent "healthy" status bits from three users, each already cleaned up upstream, and votes on them. In the normal configuration the loop is opened when any two of the three users report a fault. A static strap selects a reduced configuration instead, in which only users 0 and 1 count and either one alone can open the loop. The decision drives a loop-breaker output, where 1 means "open the loop".

The block also samples the state of each of the three loop links. It hands each one back to its own user on a separate echo line, with no voting on that path, so that every user can run its own evaluation. For remote testing, a monitoring command word can substitute a three-bit test pattern for the live user bits. The substitution takes effect only while a hardware test-enable strap is high.

A 16-bit status word reports what the vote saw, the echoed link states, the decision, the configuration and whether test substitution is active. Every input passes through one register stage, and every output is registered once more. A change at the inputs therefore reaches the outputs after two rising clock edges.

Top module: `intlk_voter`

## Requirements
- R1: While reset is high at a rising edge, the outputs become `brk_open_o`=1, `echo_o`=0 and `status_o`=16'h0040.
- R2: With `mode_2oo3_i`=1, `brk_open_o` is 1 when two or more of the three effective user bits are 0, and 0 otherwise. It reflects the inputs present two rising edges earlier.
- R3: With `mode_2oo3_i`=0, `brk_open_o` is 1 exactly when effective bit 0 or effective bit 1 is 0. Bit 2 has no effect on `brk_open_o`. The latency is the same as in R2.
- R4: `echo_o[i]` equals `loop_sense_i[i]` from two rising edges earlier, for each link i, whatever the vote result.
- R5: After reset is released, `brk_open_o` stays 1 through the first rising edge. It follows the vote only from the second edge onward.
- R6: When `hw_test_en_i`=1 and `cmd_i[0]`=1, the effective user bit i is `cmd_i[1+i]`, and the live `usr_ok_i` is ignored. In every other case the effective bits equal `usr_ok_i`.
- R7: When `hw_test_en_i`=0, `cmd_i` has no effect on any output, and status bit 8 reads 0.
- R8: `status_o` carries the following fields:
  - bits [2:0]: the effective user bits.
  - bits [5:3]: the same value as `echo_o`.
  - bit 6: equal to `brk_open_o`.
  - bit 7: the mode (1 = two-of-three).
  - bit 8: test substitution active.
  All fields come from the same sample.
- R9: `status_o[15:9]` is always 0, whatever the upper command bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_ok_i | input | 3 | User status, 1 = healthy |
| mode_2oo3_i | input | 1 | Static strap: 1 = two-of-three, 0 = one-of-two on users 0 and 1 |
| hw_test_en_i | input | 1 | Hardware permission for test substitution |
| loop_sense_i | input | 3 | Read-back state of each loop link |
| cmd_i | input | 16 | Monitoring command word: bit 0 requests test, bits [3:1] pattern |
| brk_open_o | output | 1 | Loop-breaker drive, 1 = open loop |
| echo_o | output | 3 | Per-link loop state returned to each user |
| status_o | output | 16 | Monitoring status word |

## Verification
A corrupted sample register would show as a wrong breaker decision, or as a wrong effective-bit field in `status_o`, exactly two edges after the faulty input. The bench compares every output against its model on every cycle, so the error is caught in that same cycle. A fault in the test gate would be visible as status bit 8 set, or as the pattern reaching the vote, while `hw_test_en_i` is low. A fault in the start-up interlock would let the breaker close one cycle early after reset is released, and the explicit start-up checks catch this.

// File: rtl/intlk_pkg.sv
package intlk_pkg;
  localparam int NCH    = 3;
  localparam int WORD_W = 16;
  // status field positions
  localparam int ST_EFF_LSB  = 0;
  localparam int ST_ECHO_LSB = ST_EFF_LSB + NCH;
  localparam int ST_OPEN_BIT = ST_ECHO_LSB + NCH;
  localparam int ST_MODE_BIT = ST_OPEN_BIT + 1;
  localparam int ST_TEST_BIT = ST_MODE_BIT + 1;
  localparam int ST_RSVD_LSB = ST_TEST_BIT + 1;
  // command field positions
  localparam int CMD_TEN_BIT = 0;
  localparam int CMD_PAT_LSB = 1;

  typedef struct packed {
    logic           valid;
    logic           mode3;
    logic           test;
    logic [NCH-1:0] eff;
    logic [NCH-1:0] sense;
  } smp_t;
endpackage

// File: rtl/intlk_in_stage.sv
module intlk_in_stage
  import intlk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    usr_ok_i,
  input  logic              mode_i,
  input  logic              hw_test_en_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic [NCH-1:0]    sense_i,
  output smp_t              smp_o
);
  logic           test_req;
  logic [NCH-1:0] pick;

  assign test_req = hw_test_en_i & cmd_i[CMD_TEN_BIT];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_mux
      assign pick[c] = test_req ? cmd_i[CMD_PAT_LSB + c] : usr_ok_i[c];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_o <= '0;
    end else begin
      smp_o.valid <= 1'b1;
      smp_o.mode3 <= mode_i;
      smp_o.test  <= test_req;
      smp_o.eff   <= pick;
      smp_o.sense <= sense_i;
    end
  end

  AST_TEST_GATED: assert property (@(posedge clk) disable iff (rst)
    !hw_test_en_i |=> !smp_o.test); // R7
endmodule

// File: rtl/intlk_vote.sv
module intlk_vote
  import intlk_pkg::*;
(
  input  logic [NCH-1:0] ok_i,
  input  logic           mode3_i,
  output logic           open_o
);
  localparam int QUORUM = NCH / 2 + 1;
  int n_bad;

  always_comb begin
    n_bad = 0;
    for (int c = 0; c < NCH; c++) begin
      if (!ok_i[c]) n_bad = n_bad + 1;
    end
    if (mode3_i) open_o = (n_bad >= QUORUM);
    else         open_o = ~(ok_i[0] & ok_i[1]);
  end
endmodule

// File: rtl/intlk_stat_pack.sv
module intlk_stat_pack
  import intlk_pkg::*;
(
  input  smp_t              smp_i,
  input  logic              open_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o                        = '0;
    word_o[ST_EFF_LSB  +: NCH]    = smp_i.eff;
    word_o[ST_ECHO_LSB +: NCH]    = smp_i.sense;
    word_o[ST_OPEN_BIT]           = open_i;
    word_o[ST_MODE_BIT]           = smp_i.mode3;
    word_o[ST_TEST_BIT]           = smp_i.test;
  end
endmodule

// File: rtl/intlk_voter.sv
module intlk_voter
  import intlk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    usr_ok_i,
  input  logic              mode_2oo3_i,
  input  logic              hw_test_en_i,
  input  logic [NCH-1:0]    loop_sense_i,
  input  logic [WORD_W-1:0] cmd_i,
  output logic              brk_open_o,
  output logic [NCH-1:0]    echo_o,
  output logic [WORD_W-1:0] status_o
);
  localparam logic [WORD_W-1:0] STAT_RST = WORD_W'(1) << ST_OPEN_BIT;

  smp_t              smp_q;
  logic              vote_open;
  logic              gate_open;
  logic [WORD_W-1:0] word_d;

  intlk_in_stage u_in (
    .clk          (clk),
    .rst          (rst),
    .usr_ok_i     (usr_ok_i),
    .mode_i       (mode_2oo3_i),
    .hw_test_en_i (hw_test_en_i),
    .cmd_i        (cmd_i),
    .sense_i      (loop_sense_i),
    .smp_o        (smp_q)
  );

  intlk_vote u_vote (
    .ok_i    (smp_q.eff),
    .mode3_i (smp_q.mode3),
    .open_o  (vote_open)
  );

  // no valid sample yet: hold the loop open
  assign gate_open = vote_open | ~smp_q.valid;

  intlk_stat_pack u_pack (
    .smp_i  (smp_q),
    .open_i (gate_open),
    .word_o (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_open_o <= 1'b1;
      echo_o     <= '0;
      status_o   <= STAT_RST;
    end else begin
      brk_open_o <= gate_open;
      echo_o     <= smp_q.sense;
      status_o   <= word_d;
    end
  end

  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> brk_open_o); // R1
  AST_WARMUP_OPEN: assert property (@(posedge clk) disable iff (rst)
    !smp_q.valid |=> brk_open_o); // R5
  AST_MAJ_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (smp_q.valid && smp_q.mode3 && $countones(smp_q.eff) >= 2) |=> !brk_open_o); // R2
  AST_MAJ_OPEN: assert property (@(posedge clk) disable iff (rst)
    (smp_q.valid && smp_q.mode3 && $countones(smp_q.eff) <= 1) |=> brk_open_o); // R2
  AST_PAIR_VOTE: assert property (@(posedge clk) disable iff (rst)
    (smp_q.valid && !smp_q.mode3) |=> (brk_open_o == !($past(smp_q.eff[0]) && $past(smp_q.eff[1])))); // R3
  AST_ECHO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    smp_q.valid |=> (echo_o == $past(smp_q.sense))); // R4
  AST_STAT_OPEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    status_o[ST_OPEN_BIT] == brk_open_o); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[WORD_W-1:ST_RSVD_LSB] == '0); // R9
endmodule

// File: tb/sim_intlk_voter.sv
module sim_intlk_voter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  usr_ok_i = '0;
  logic        mode_2oo3_i = 1'b1;
  logic        hw_test_en_i = 1'b0;
  logic [2:0]  loop_sense_i = '0;
  logic [15:0] cmd_i = '0;
  logic        brk_open_o;
  logic [2:0]  echo_o;
  logic [15:0] status_o;

  intlk_voter u0 (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  string ph = "R1";

  // behavioural reference model
  bit        m_valid, m_mode, m_test;
  bit [2:0]  m_ef, m_sense;
  bit        e_brk;
  bit [2:0]  e_echo;
  bit [15:0] e_stat;
  int        n_bad;
  bit        open;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_mode = 0; m_test = 0; m_ef = 0; m_sense = 0;
      e_brk = 1; e_echo = 0; e_stat = 16'h0040;
    end else begin
      n_bad = 0;
      for (int i = 0; i < 3; i++) if (!m_ef[i]) n_bad++;
      if (!m_valid)   open = 1;
      else if (m_mode) open = (n_bad >= 2);
      else            open = !(m_ef[0] && m_ef[1]);
      e_brk  = open;
      e_echo = m_sense;
      e_stat = {7'b0, m_test, m_mode, open, m_sense, m_ef};
      m_test  = hw_test_en_i && cmd_i[0];
      m_ef    = m_test ? cmd_i[3:1] : usr_ok_i;
      m_mode  = mode_2oo3_i;
      m_sense = loop_sense_i;
      m_valid = 1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      total++;
      if (brk_open_o !== e_brk) begin
        bad++;
        $display("FAIL %s brk_open_o act=%0b exp=%0b", ph, brk_open_o, e_brk);
      end
      total++;
      if (echo_o !== e_echo) begin
        bad++;
        $display("FAIL R4 (%s) echo_o act=%0h exp=%0h", ph, echo_o, e_echo);
      end
      total++;
      if (status_o !== e_stat) begin
        bad++;
        $display("FAIL R8/R9 (%s) status_o act=%04h exp=%04h", ph, status_o, e_stat);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk_on = 1'b1;
    // R1 reset state
    chk("R1 brk", brk_open_o, 1);
    chk("R1 echo", echo_o, 0);
    chk("R1 status", status_o, 16'h0040);

    // R5 start-up: healthy inputs, breaker must stay open one edge
    ph = "R5";
    usr_ok_i = 3'b111; mode_2oo3_i = 1; loop_sense_i = 3'b111;
    rst = 0;
    tick(1);
    chk("R5 first edge brk", brk_open_o, 1);
    tick(1);
    chk("R5 second edge brk", brk_open_o, 0);

    // R2 two-of-three, all patterns
    ph = "R2";
    for (int p = 0; p < 8; p++) begin
      usr_ok_i = p[2:0];
      tick(2);
      chk("R2 vote", brk_open_o, ($countones(p[2:0]) <= 1) ? 1 : 0);
    end

    // R3 one-of-two, input 2 ignored
    ph = "R3";
    mode_2oo3_i = 0;
    for (int p = 0; p < 8; p++) begin
      usr_ok_i = p[2:0];
      tick(2);
      chk("R3 vote", brk_open_o, (p[0] && p[1]) ? 0 : 1);
      chk("R8 mode bit", status_o[7], 0);
    end
    usr_ok_i = 3'b011; tick(2);
    chk("R3 bit2 ignored", brk_open_o, 0);

    // R4 echo independent of vote
    ph = "R4";
    mode_2oo3_i = 1;
    for (int k = 0; k < 20; k++) begin
      loop_sense_i = 3'($urandom);
      usr_ok_i = 3'($urandom);
      tick(1);
    end

    // R6 test substitution allowed
    ph = "R6";
    hw_test_en_i = 1;
    cmd_i = 16'h0001; usr_ok_i = 3'b111; tick(2);
    chk("R6 pattern 000 opens", brk_open_o, 1);
    chk("R6 test flag", status_o[8], 1);
    chk("R6 eff field", status_o[2:0], 0);
    for (int k = 0; k < 30; k++) begin
      cmd_i = 16'($urandom) | 16'h0001;
      usr_ok_i = 3'($urandom);
      mode_2oo3_i = 1'($urandom);
      tick(1);
    end

    // R7 gate low: command ignored
    ph = "R7";
    hw_test_en_i = 0; mode_2oo3_i = 1;
    cmd_i = 16'h0001; usr_ok_i = 3'b111; tick(2);
    chk("R7 cmd ignored brk", brk_open_o, 0);
    chk("R7 test flag", status_o[8], 0);
    chk("R7 eff field", status_o[2:0], 3'b111);
    for (int k = 0; k < 30; k++) begin
      cmd_i = 16'($urandom);
      usr_ok_i = 3'($urandom);
      tick(1);
    end

    // R9 random traffic with upper command bits
    ph = "R9";
    for (int k = 0; k < 200; k++) begin
      cmd_i = 16'($urandom);
      hw_test_en_i = 1'($urandom);
      usr_ok_i = 3'($urandom);
      loop_sense_i = 3'($urandom);
      mode_2oo3_i = 1'($urandom);
      tick(1);
      chk("R9 reserved", status_o[15:9], 0);
    end

    // R1 reset again mid-run
    ph = "R1";
    rst = 1; tick(2);
    chk("R1 re-reset brk", brk_open_o, 1);
    chk("R1 re-reset status", status_o, 16'h0040);
    ph = "R5";
    hw_test_en_i = 0; usr_ok_i = 3'b111; mode_2oo3_i = 1;
    rst = 0; tick(1);
    chk("R5 re-release brk", brk_open_o, 1);
    tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule